// File: doc/BRIEF.md
# Shared Serial Peripheral Controller

This block is a serial bus master that drives one clock line, one outgoing data line and one incoming data line shared by two peripherals: a non-volatile memory, whose select is active high, and an analog-to-digital converter, whose select is active low. A single command (`start` with an operation code, an address word and an optional write word) runs one complete frame. The block asserts the matching select, clocks the frame out MSB first and returns the captured word on `rdata` with a one-cycle `done` pulse.

The two peripherals use different framing. A memory frame is always 32 bit times long. A read sends the 16-bit code/address word and then clocks in 16 data bits. A write sends the code/address word and then the 16-bit write word. The memory itself decodes only the low 9 bits of the code/address word. A converter frame is 8 bit times and full duplex: the address byte goes out while the byte coming in holds the result of the conversion requested in the previous converter frame. The converter uses only the top 4 bits of the byte. Because the first converter frame after reset has no earlier request, its result is flagged invalid.

Alongside the bus, the block divides the system clock by 8 to produce a free-running conversion clock for the converter.

Top module: `ser_periph_ctrl`

## Requirements
- R1: `mem_sel` is high exactly during memory frames and `adc_sel_n` is low exactly during converter frames. The two are never active together, both are inactive while no frame runs, and the active select holds for the whole frame, including every phase where `sclk` is high.
- R2: A memory read (`op`=2'b00) lasts 32 `sclk` periods. `sdo` carries `addr` MSB first in the first 16 bit times and is 0 in the last 16. The `sdi` bits sampled at the last 16 rising edges form `rdata`, MSB first.
- R3: A memory write (`op`=2'b01) lasts 32 `sclk` periods. `sdo` carries `addr` MSB first and then `wdata` MSB first, and `rdata` is left unchanged.
- R4: A converter frame (`op`=2'b10) lasts 8 `sclk` periods. `sdo` carries `addr[7:0]` MSB first. The 8 `sdi` bits sampled at the rising edges form `rdata[7:0]`, MSB first, and `rdata[15:8]` is 0.
- R5: At `done` of the first converter frame after reset, `adc_valid` is 0. At `done` of every later converter frame it is 1. Memory frames leave `adc_valid` unchanged.
- R6: `sdo` changes only at the system edge where `sclk` falls or where a frame starts (with `sclk` low), so it is stable while `sclk` is high. `sdi` is sampled at the edge where `sclk` rises.
- R7: `conv_clk` is low in reset, first goes high at the 4th rising system clock edge after reset release, and then repeats a period of 8 system cycles: 4 high and 4 low.
- R8: `sclk` is low between frames. Each `sclk` half period lasts SCK_HALF (default 2) system cycles. The first rise comes SCK_HALF cycles after the select asserts, and the last fall comes at the same edge that releases the select, so a frame of N bits ends 2·SCK_HALF·N edges after it was accepted.
- R9: A `start` while `busy` is high is ignored and does not change the running frame. A `start` with `op`=2'b11 is ignored and leaves `busy` and both selects inactive.
- R10: `busy` and the select rise at the edge that accepts `start`. `done` is high for exactly one cycle, at the edge that ends the frame. In that cycle `busy` is already low and `rdata`/`adc_valid` hold the new result.
- R11: `sdo` is 0 whenever no frame is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a frame when idle |
| op | input | 2 | 00 memory read, 01 memory write, 10 converter, 11 no-op |
| addr | input | 16 | Memory code/address word, or converter address in bits 7:0 |
| wdata | input | 16 | Memory write word |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rdata | output | 16 | Captured read word or converter result |
| adc_valid | output | 1 | Converter result refers to a real earlier request |
| sclk | output | 1 | Shared serial clock |
| sdo | output | 1 | Shared serial data to peripherals |
| sdi | input | 1 | Shared serial data from peripherals |
| mem_sel | output | 1 | Memory select, active high |
| adc_sel_n | output | 1 | Converter select, active low |
| conv_clk | output | 1 | System clock divided by 8 |

## Verification
The bench runs behavioural memory and converter models on the serial lines, so a frame that is cut short or mis-ordered, or that drives data on the wrong edge, shows up as a wrong captured address, a wrong stored word or a wrong read result. The pipelined converter result is a key case. A design that returned the current request's result, or that flagged the first result valid, would fail the first two converter frames. The bench sends a second `start` in the middle of a write frame. A design that accepted it would corrupt the captured write or emit two `done` pulses. The bench also measures the frame length and every `sclk` half period, and it checks `conv_clk` against a free-running count on every cycle, so an off-by-one in either divider is caught.

// File: rtl/ser_pkg.sv
package ser_pkg;

   typedef enum logic [1:0] {
      OP_MEM_RD = 2'b00,
      OP_MEM_WR = 2'b01,
      OP_ADC    = 2'b10,
      OP_NONE   = 2'b11
   } op_e;

endpackage

// File: rtl/ser_conv_div.sv
module ser_conv_div #(
   parameter int DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic conv_clk
);
   localparam int CW       = (DIV > 2) ? $clog2(DIV) : 1;
   localparam int HALF_DIV = DIV / 2;
   localparam bit POW2     = ((DIV & (DIV - 1)) == 0);

   if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
      $error("ser_conv_div: DIV must be even and at least 2");
   end

   logic [CW-1:0] cnt_q, cnt_d;
   logic          conv_d, conv_q;

   if (POW2) begin : g_pow2
      // Natural wrap of the counter; the top bit is the divided clock.
      always_comb begin
         cnt_d  = cnt_q + 1'b1;
         conv_d = cnt_d[CW-1];
      end
   end else begin : g_gen
      always_comb begin
         cnt_d  = (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
         conv_d = (cnt_d >= CW'(HALF_DIV));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         conv_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         conv_q <= conv_d;
      end
   end

   assign conv_clk = conv_q;

endmodule

// File: rtl/ser_bit_clock.sv
module ser_bit_clock #(
   parameter int HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk,
   output logic rise,
   output logic fall
);
   localparam int CW = (HALF > 2) ? $clog2(HALF) : 1;

   if (HALF < 1) begin : g_bad_half
      $error("ser_bit_clock: HALF must be at least 1");
   end

   logic tick;
   logic sclk_q;

   if (HALF == 1) begin : g_fast
      assign tick = run;
   end else begin : g_count
      logic [CW-1:0] ph_q;
      assign tick = run && (ph_q == CW'(HALF - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            ph_q <= '0;
         else if (!run || tick) ph_q <= '0;
         else                   ph_q <= ph_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sclk_q <= 1'b0;
      else if (!run) sclk_q <= 1'b0;
      else if (tick) sclk_q <= ~sclk_q;
   end

   assign rise = tick & ~sclk_q;
   assign fall = tick &  sclk_q;
   assign sclk = sclk_q;

endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
   parameter int OUT_W = 32,
   parameter int IN_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [OUT_W-1:0] load_word,
   input  logic             shift_out,
   input  logic             sample,
   input  logic             sdi,
   output logic             sdo,
   output logic [IN_W-1:0]  in_word
);
   if (OUT_W < 2 || IN_W < 2) begin : g_bad_w
      $error("ser_shift: widths must be at least 2");
   end

   logic [OUT_W-1:0] out_q;
   logic [IN_W-1:0]  in_q;

   // Outgoing word: zeros shift in behind the data, so the line rests low.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         out_q <= '0;
      else if (load)      out_q <= load_word;
      else if (shift_out) out_q <= {out_q[OUT_W-2:0], 1'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      in_q <= '0;
      else if (load)   in_q <= '0;
      else if (sample) in_q <= {in_q[IN_W-2:0], sdi};
   end

   assign sdo     = out_q[OUT_W-1];
   assign in_word = in_q;

endmodule

// File: rtl/ser_periph_ctrl.sv
module ser_periph_ctrl #(
   parameter int CODE_W   = 16,
   parameter int MDATA_W  = 16,
   parameter int ADC_W    = 8,
   parameter int SCK_HALF = 2,
   parameter int CONV_DIV = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [1:0]         op,
   input  logic [CODE_W-1:0]  addr,
   input  logic [MDATA_W-1:0] wdata,
   output logic               busy,
   output logic               done,
   output logic [MDATA_W-1:0] rdata,
   output logic               adc_valid,
   output logic               sclk,
   output logic               sdo,
   input  logic               sdi,
   output logic               mem_sel,
   output logic               adc_sel_n,
   output logic               conv_clk
);
   import ser_pkg::*;

   localparam int MEM_BITS = CODE_W + MDATA_W;
   localparam int SH_W     = MEM_BITS;
   localparam int BW       = $clog2(SH_W + 1);

   if (ADC_W > CODE_W || ADC_W > MDATA_W || ADC_W < 2) begin : g_bad_adc
      $error("ser_periph_ctrl: ADC_W must fit both memory words");
   end

   logic              busy_q, done_q, mem_sel_q, adc_seln_q;
   logic              seen_q, valid_q;
   op_e               op_q;
   logic [BW-1:0]     bits_q;
   logic [MDATA_W-1:0] rdata_q;

   logic              accept, finish;
   logic              rise, fall;
   logic [SH_W-1:0]   load_word;
   logic [MDATA_W-1:0] in_word;

   assign accept = start && !busy_q && (op_e'(op) != OP_NONE);
   assign finish = busy_q && fall && (bits_q == BW'(1));

   // Frame image, MSB first, left aligned in the shifter.
   always_comb begin
      unique case (op_e'(op))
         OP_MEM_RD: load_word = {addr, MDATA_W'(0)};
         OP_MEM_WR: load_word = {addr, wdata};
         OP_ADC:    load_word = SH_W'(addr[ADC_W-1:0]) << (SH_W - ADC_W);
         default:   load_word = '0;
      endcase
   end

   ser_bit_clock #(.HALF(SCK_HALF)) u_bclk (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy_q),
      .sclk  (sclk),
      .rise  (rise),
      .fall  (fall)
   );

   ser_shift #(.OUT_W(SH_W), .IN_W(MDATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_word (load_word),
      .shift_out (busy_q && fall),
      .sample    (busy_q && rise),
      .sdi       (sdi),
      .sdo       (sdo),
      .in_word   (in_word)
   );

   ser_conv_div #(.DIV(CONV_DIV)) u_conv (
      .clk      (clk),
      .rst_n    (rst_n),
      .conv_clk (conv_clk)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         done_q     <= 1'b0;
         mem_sel_q  <= 1'b0;
         adc_seln_q <= 1'b1;
         op_q       <= OP_MEM_RD;
         bits_q     <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q     <= 1'b1;
            op_q       <= op_e'(op);
            bits_q     <= (op_e'(op) == OP_ADC) ? BW'(ADC_W) : BW'(MEM_BITS);
            mem_sel_q  <= (op_e'(op) != OP_ADC);
            adc_seln_q <= (op_e'(op) != OP_ADC);
         end else if (busy_q && fall) begin
            if (finish) begin
               busy_q     <= 1'b0;
               done_q     <= 1'b1;
               mem_sel_q  <= 1'b0;
               adc_seln_q <= 1'b1;
            end else begin
               bits_q <= bits_q - 1'b1;
            end
         end
      end
   end

   // Result capture and converter pipeline validity.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         seen_q  <= 1'b0;
         valid_q <= 1'b0;
      end else if (finish) begin
         if (op_q == OP_MEM_RD) begin
            rdata_q <= in_word;
         end else if (op_q == OP_ADC) begin
            rdata_q <= MDATA_W'(in_word[ADC_W-1:0]);
            valid_q <= seen_q;
            seen_q  <= 1'b1;
         end
      end
   end

   assign busy      = busy_q;
   assign done      = done_q;
   assign rdata     = rdata_q;
   assign adc_valid = valid_q;
   assign mem_sel   = mem_sel_q;
   assign adc_sel_n = adc_seln_q;

endmodule

// File: rtl/ser_periph_ctrl_chk.sv
module ser_periph_ctrl_chk #(
   parameter int CONV_DIV = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic [1:0] op,
   input logic       busy,
   input logic       done,
   input logic       sclk,
   input logic       sdo,
   input logic       mem_sel,
   input logic       adc_sel_n,
   input logic       conv_clk
);
   localparam int HALF_DIV = CONV_DIV / 2;
   localparam int RW       = $clog2(CONV_DIV + 1);

   logic          conv_last;
   logic [RW-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_last <= 1'b0;
         run_len   <= '0;
      end else begin
         conv_last <= conv_clk;
         if (conv_clk != conv_last) run_len <= RW'(1);
         else                       run_len <= run_len + 1'b1;
      end
   end

   AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_sel && !adc_sel_n)); // R1
   AST_SEL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_sel || !adc_sel_n) |-> busy); // R1
   AST_SEL_HELD_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> (mem_sel || !adc_sel_n)); // R1
   AST_SDO_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(sdo)); // R6
   AST_CONV_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_clk != conv_last) |-> (run_len == RW'(HALF_DIV))); // R7
   AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_sel && adc_sel_n) |-> !sclk); // R8
   AST_NOOP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && op == 2'b11) |=> !busy); // R9
   AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && op != 2'b11) |=> busy); // R10
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R10
   AST_SDO_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sdo); // R11

endmodule

bind ser_periph_ctrl ser_periph_ctrl_chk #(.CONV_DIV(CONV_DIV)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .op        (op),
   .busy      (busy),
   .done      (done),
   .sclk      (sclk),
   .sdo       (sdo),
   .mem_sel   (mem_sel),
   .adc_sel_n (adc_sel_n),
   .conv_clk  (conv_clk)
);

// File: tb/ser_periph_ctrl_tb.sv
module ser_periph_ctrl_tb;
   localparam int HALF = 2;
   localparam int DIV  = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'b00;
   logic [15:0] addr = '0;
   logic [15:0] wdata = '0;
   logic        sdi = 1'b0;
   logic        busy, done, adc_valid, sclk, sdo, mem_sel, adc_sel_n, conv_clk;
   logic [15:0] rdata;

   ser_periph_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr),
      .wdata(wdata), .busy(busy), .done(done), .rdata(rdata),
      .adc_valid(adc_valid), .sclk(sclk), .sdo(sdo), .sdi(sdi),
      .mem_sel(mem_sel), .adc_sel_n(adc_sel_n), .conv_clk(conv_clk)
   );

   always #4 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Behavioural memory peripheral (decodes low 9 code bits).
   logic [15:0] bmem [0:511];
   logic [15:0] mcode, mdat, mrd;
   logic [1:0]  cur_op = 2'b00;
   int          mk = 0;

   // Behavioural converter peripheral (result lags one request).
   logic [7:0]  aaddr, apend = 8'hC3;
   bit          ahave = 1'b0;
   int          ak = 0;

   always @(posedge mem_sel) mk = 0;
   always @(negedge adc_sel_n) if (rst_n) begin ak = 0; sdi = apend[7]; end

   always @(posedge sclk) begin
      if (mem_sel) begin
         if (mk < 16) mcode = {mcode[14:0], sdo};
         else         mdat  = {mdat[14:0], sdo};
         mk++;
         if (mk == 16) mrd = bmem[mcode[8:0]];
         if (mk == 32 && cur_op == 2'b01) bmem[mcode[8:0]] = mdat;
      end
      if (!adc_sel_n) begin
         aaddr = {aaddr[6:0], sdo};
         ak++;
      end
   end

   always @(negedge sclk) begin
      if (mem_sel && cur_op == 2'b00 && mk >= 16 && mk < 32) sdi = mrd[31 - mk];
      if (!adc_sel_n && ak < 8) sdi = apend[7 - ak];
   end

   always @(posedge adc_sel_n) begin
      if (rst_n && ak == 8) begin
         apend = {aaddr[7:4], ~aaddr[7:4]};
         ahave = 1'b1;
         ak = 0;
      end
   end

   // Cycle-by-cycle reference for the divider and line timing.
   int   bc = 0;
   int   run = 0;
   logic psclk = 1'b0, psdo = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) bc = 0;
      else        bc = (bc + 1) % DIV;
   end

   always @(negedge clk) begin
      check("R7", "conv_clk", 32'(conv_clk), 32'(bc >= DIV / 2));
      if (rst_n) begin
         check("R1", "both selects active", 32'(mem_sel && !adc_sel_n), 32'd0);
         if (!mem_sel && adc_sel_n) begin
            check("R8", "sclk idle", 32'(sclk), 32'd0);
            check("R11", "sdo idle", 32'(sdo), 32'd0);
            run = 0;
         end else begin
            if (sclk != psclk) begin
               check("R8", "half period", 32'(run), 32'(HALF));
               run = 1;
            end else begin
               run++;
            end
            if (sclk && psclk) check("R6", "sdo held while sclk high", 32'(sdo), 32'(psdo));
         end
      end
      psclk = sclk;
      psdo  = sdo;
   end

   task automatic run_frame(input logic [1:0] o, input logic [15:0] a,
                            input logic [15:0] wd, input bit poke);
      int w = 0;
      int bits = (o == 2'b10) ? 8 : 32;
      @(negedge clk);
      op = o; addr = a; wdata = wd; cur_op = o; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R10", "busy after start", 32'(busy), 32'd1);
      check("R1", "mem_sel in frame", 32'(mem_sel), 32'(o != 2'b10));
      check("R1", "adc_sel_n in frame", 32'(adc_sel_n), 32'(o != 2'b10));
      if (poke) begin
         for (int i = 0; i < 10; i++) begin @(negedge clk); w++; end
         op = 2'b00; addr = ~a; wdata = ~wd; start = 1'b1;
         @(negedge clk); w++;
         start = 1'b0;
      end
      while (!done && w < 2000) begin @(negedge clk); w++; end
      check("R8", "frame length", 32'(w), 32'(bits * 2 * HALF));
      check("R10", "done pulse", 32'(done), 32'd1);
      check("R10", "busy low at done", 32'(busy), 32'd0);
      check("R1", "selects released", 32'({mem_sel, adc_sel_n}), 32'b01);
   endtask

   task automatic after_done(input int dummy);
      @(negedge clk);
      check("R10", "done one cycle", 32'(done), 32'd0 + 32'(dummy));
   endtask

   logic [15:0] exp16;
   logic [7:0]  exp8;
   bit          expv;
   logic [15:0] prev_rd;

   initial begin
      for (int i = 0; i < 512; i++) bmem[i] = 16'(i * 37) ^ 16'h5A5A;
      repeat (3) @(negedge clk);
      check("R10", "reset busy", 32'(busy), 32'd0);
      check("R10", "reset done", 32'(done), 32'd0);
      check("R1", "reset selects", 32'({mem_sel, adc_sel_n}), 32'b01);
      check("R5", "reset adc_valid", 32'(adc_valid), 32'd0);
      check("R8", "reset sclk", 32'(sclk), 32'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // Write with a second start attempted mid-frame.
      prev_rd = rdata;
      run_frame(2'b01, 16'h305A, 16'hBEEF, 1'b1);
      check("R3", "write code captured", 32'(mcode), 32'h305A);
      check("R3", "write data captured", 32'(mdat), 32'hBEEF);
      check("R9", "stored word unaffected by poke", 32'(bmem[9'h05A]), 32'hBEEF);
      check("R3", "rdata unchanged by write", 32'(rdata), 32'(prev_rd));
      after_done(0);
      check("R9", "no second frame", 32'(busy), 32'd0);

      run_frame(2'b00, 16'hA05A, 16'h0000, 1'b0);
      check("R2", "read code captured", 32'(mcode), 32'hA05A);
      check("R2", "sdo low in data phase", 32'(mdat), 32'h0000);
      check("R2", "read data", 32'(rdata), 32'hBEEF);
      after_done(0);

      exp16 = bmem[9'h1FF];
      run_frame(2'b00, 16'h81FF, 16'h1234, 1'b0);
      check("R2", "read code 2", 32'(mcode), 32'h81FF);
      check("R2", "read data 2", 32'(rdata), 32'(exp16));
      check("R5", "valid untouched by memory", 32'(adc_valid), 32'd0);

      exp8 = apend; expv = ahave;
      run_frame(2'b10, 16'hFF5A, 16'h0000, 1'b0);
      check("R4", "adc address", 32'(aaddr), 32'h5A);
      check("R4", "adc first result", 32'(rdata), 32'(exp8));
      check("R5", "first result invalid", 32'(adc_valid), 32'(expv));
      check("R5", "first result invalid const", 32'(adc_valid), 32'd0);

      run_frame(2'b00, 16'h005A, 16'h0000, 1'b0);
      check("R5", "valid untouched by memory 2", 32'(adc_valid), 32'd0);

      exp8 = apend;
      run_frame(2'b10, 16'h00A3, 16'h0000, 1'b0);
      check("R4", "adc address 2", 32'(aaddr), 32'hA3);
      check("R4", "adc pipelined result", 32'(rdata), 32'(exp8));
      check("R4", "adc pipelined value", 32'(rdata), 32'h005A);
      check("R5", "second result valid", 32'(adc_valid), 32'd1);

      run_frame(2'b10, 16'h00F0, 16'h0000, 1'b0);
      check("R4", "adc third result", 32'(rdata), 32'h00A5);
      check("R5", "third result valid", 32'(adc_valid), 32'd1);

      // No-op code is ignored.
      @(negedge clk);
      op = 2'b11; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R9", "noop busy", 32'(busy), 32'd0);
      check("R9", "noop selects", 32'({mem_sel, adc_sel_n}), 32'b01);
      repeat (6) @(negedge clk);
      check("R9", "noop no done", 32'(done), 32'd0);
      check("R11", "noop sdo", 32'(sdo), 32'd0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule